// File: doc/BRIEF.md
# Row Delay Buffer

This block delays a stream of 24-bit pixel words by a run-time chosen number of clock cycles. A 1024-word RAM is addressed by a counter that advances once per clock. Every cycle the word held at the current address is read out, and the incoming word then overwrites that same location. The next time the counter comes back to that address, the word leaves the block. An active-low row-start strobe clears the counter, so the period of that strobe sets the row length.

The delay is set by the stimulus and not by a parameter. If the strobe is sampled low once every P cycles, each input word comes out P + 4 cycles later. The fixed 4 cycles are three input pipeline stages plus one output register. If the strobe stays high long enough, the counter stops at its last address, 1023. It stays there, and the RAM is no longer written. Before a full row has passed since the first strobe, the output holds stale data.

Top module: `rdb_row_delay`

## Requirements
- R1: While `rst` is sampled high, the address counter and all pipeline registers clear, and `pix_out` reads 0 after that clock edge.
- R2: When `row_start_n` is sampled low on exactly one edge in every P consecutive edges, with 1 <= P <= 1023, a word sampled on edge e appears on `pix_out` just after edge e + P + 4. This holds from P + 4 edges after the first such strobe.
- R3: The shortest period, P = 1 (the strobe held low every cycle), gives a delay of exactly 5 cycles.
- R4: With `row_start_n` held high, the counter advances by one per cycle until it reaches 1023 and then holds there. From then on, no RAM write takes place, and `pix_out` stays constant whatever `pix_in` does.
- R5: A low sample of `row_start_n` sets the counter to 0 on that edge from any state, the saturated state included. A new period therefore takes effect P + 4 edges after its first strobe.
- R6: Each cycle the RAM returns the word stored at the current address before the write of that cycle, so a period of P returns data written exactly P cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| row_start_n | input | 1 | Row start strobe, active low; clears the address counter |
| pix_in | input | 24 | Incoming pixel word |
| pix_out | output | 24 | Pixel word delayed by the row period plus 4 |

## Verification
The delay is measured with strobe periods of 6, 1, 37, 200 and 1023. A single wrong latency stage or a write-before-read RAM would show up as an offset at every period. An error in the counter range would show up only at the short or long end. Varying data is then driven with the strobe held high for more than 1024 cycles. A constant output in that phase separates a saturating, write-disabled counter from one that wraps or keeps writing. Period 9 after saturation and period 12 after a mid-stream reset show that the strobe and the reset both restore normal operation.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
    localparam int RDB_DATA_W    = 24;
    localparam int RDB_ADDR_W    = 10;
    localparam int RDB_IN_STAGES = 3;

    typedef enum logic [1:0] {
        CTR_RESTART = 2'd0,
        CTR_STEP    = 2'd1,
        CTR_HOLD    = 2'd2
    } rdb_ctr_mode_e;
endpackage

// File: rtl/rdb_addr_ctr.sv
module rdb_addr_ctr
    import rdb_pkg::*;
#(
    parameter int ADDR_W = RDB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_start_n,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en
);
    localparam logic [ADDR_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t    st_d, st_q;
    rdb_ctr_mode_e mode;

    always_comb begin
        st_d = st_q;
        if (!row_start_n) begin
            mode = CTR_RESTART;
        end else if (st_q.cnt == CNT_MAX) begin
            mode = CTR_HOLD;
        end else begin
            mode = CTR_STEP;
        end
        case (mode)
            CTR_RESTART: st_d.cnt = '0;
            CTR_STEP:    st_d.cnt = st_q.cnt + ADDR_W'(1);
            default:     st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr  = st_q.cnt;
    assign wr_en = (st_q.cnt != CNT_MAX);

    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        !row_start_n |=> addr == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (row_start_n && addr != CNT_MAX) |=> addr == $past(addr) + ADDR_W'(1));

    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (row_start_n && addr == CNT_MAX) |=> addr == CNT_MAX);

    p_reset_cnt_r1: assert property (@(posedge clk)
        rst |=> addr == '0);
endmodule

// File: rtl/rdb_pix_pipe.sv
module rdb_pix_pipe
    import rdb_pkg::*;
#(
    parameter int DATA_W = RDB_DATA_W,
    parameter int STAGES = RDB_IN_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [DATA_W-1:0] stg_d [STAGES];
    logic [DATA_W-1:0] stg_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_head
                always_comb stg_d[k] = din;
            end else begin : g_body
                always_comb stg_d[k] = stg_q[k-1];

                p_shift_r2: assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> stg_q[k] == $past(stg_q[k-1]));
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q[k] <= '0;
                end else begin
                    stg_q[k] <= stg_d[k];
                end
            end
        end
    endgenerate

    assign dout = stg_q[LAST];
endmodule

// File: rtl/rdb_ram_rbw.sv
module rdb_ram_rbw
    import rdb_pkg::*;
#(
    parameter int DATA_W = RDB_DATA_W,
    parameter int ADDR_W = RDB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int                DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ADR = '1;

    logic [DATA_W-1:0] mem_q [DEPTH];

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d    = rd_q;
        rd_d.rd = mem_q[addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !rst) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = rd_q.rd;

    p_no_write_sat_r4: assert property (@(posedge clk) disable iff (rst)
        (addr == LAST_ADR) |-> !wr_en);

    p_write_below_top_r6: assert property (@(posedge clk) disable iff (rst)
        (addr != LAST_ADR) |-> wr_en);
endmodule

// File: rtl/rdb_row_delay.sv
module rdb_row_delay
    import rdb_pkg::*;
#(
    parameter int DATA_W    = RDB_DATA_W,
    parameter int ADDR_W    = RDB_ADDR_W,
    parameter int IN_STAGES = RDB_IN_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_start_n,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] pix_out
);
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [DATA_W-1:0] pipe_word;
    logic [DATA_W-1:0] ram_word;

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } out_state_t;

    out_state_t out_d, out_q;

    rdb_addr_ctr #(
        .ADDR_W(ADDR_W)
    ) i_ctr (
        .clk        (clk),
        .rst        (rst),
        .row_start_n(row_start_n),
        .addr       (ram_addr),
        .wr_en      (ram_we)
    );

    rdb_pix_pipe #(
        .DATA_W(DATA_W),
        .STAGES(IN_STAGES)
    ) i_pipe (
        .clk (clk),
        .rst (rst),
        .din (pix_in),
        .dout(pipe_word)
    );

    rdb_ram_rbw #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) i_ram (
        .clk  (clk),
        .rst  (rst),
        .addr (ram_addr),
        .wr_en(ram_we),
        .wdata(pipe_word),
        .rdata(ram_word)
    );

    always_comb begin
        out_d      = out_q;
        out_d.word = ram_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pix_out = out_q.word;

    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> pix_out == '0);

    p_out_tracks_ram_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pix_out == $past(ram_word));
endmodule

// File: tb/test_rdb_row_delay.sv
module test_rdb_row_delay;
    localparam int  CLK_PERIOD = 10;
    localparam int  DW         = 24;
    localparam int  WATCHDOG   = 200000;

    logic          clk = 1'b0;
    logic          rst;
    logic          row_start_n;
    logic [DW-1:0] pix_in;
    logic [DW-1:0] pix_out;

    int            total = 0;
    int            bad   = 0;
    bit            done  = 0;
    bit            armed = 0;
    int            n_dly = 0;
    string         cur_req = "R2";
    int unsigned   seed_k = 1;
    logic [DW-1:0] exp_q [$];

    rdb_row_delay i_rdb_row_delay (
        .clk        (clk),
        .rst        (rst),
        .row_start_n(row_start_n),
        .pix_in     (pix_in),
        .pix_out    (pix_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] mix(input int unsigned k);
        int unsigned h;
        h = (k * 32'd2654435761) ^ (k >> 3) ^ 32'h005A_C3E1;
        return h[DW-1:0];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: pix_out=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compares the design output with the scoreboard after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (armed && exp_q.size() > n_dly) begin
                check(cur_req, pix_out, exp_q.pop_front());
            end
        end
    end

    // Driver: strobe once every p cycles, push every sampled word.
    task automatic run_period(input int p, input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (i == 0) begin
                exp_q.delete();
                n_dly   = p + 4;
                cur_req = req;
                armed   = 1;
            end
            row_start_n = ((i % p) == 0) ? 1'b0 : 1'b1;
            pix_in      = mix(seed_k);
            seed_k++;
            exp_q.push_back(pix_in);
        end
        @(negedge clk);
        armed = 0;
        exp_q.delete();
    endtask

    task automatic saturate();
        logic [DW-1:0] held;
        row_start_n = 1'b1;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            pix_in = mix(seed_k);
            seed_k++;
        end
        held = pix_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            pix_in = mix(seed_k);
            seed_k++;
            check("R4", pix_out, held);
        end
    endtask

    initial begin
        rst         = 1'b1;
        row_start_n = 1'b1;
        pix_in      = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pix_in = mix(seed_k);
            seed_k++;
            check("R1", pix_out, '0);
        end
        rst = 1'b0;

        run_period(6, 80, "R2");       // 10-cycle delay
        run_period(1, 40, "R3");       // minimum period, 5-cycle delay
        run_period(37, 200, "R2");
        run_period(200, 600, "R6");
        run_period(1023, 1100, "R2");  // longest period without saturation
        saturate();
        run_period(9, 60, "R5");       // recovery from the saturated state

        @(negedge clk);
        rst         = 1'b1;
        row_start_n = 1'b1;
        @(negedge clk);
        check("R1", pix_out, '0);
        @(negedge clk);
        check("R1", pix_out, '0);
        rst = 1'b0;
        run_period(12, 60, "R5");

        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end
endmodule